// File: doc/BRIEF.md
# DS3 Loss-of-Signal Detector

The block watches the recovered receive bit stream of a DS3 line, one bit on every cycle where the bit-valid enable is high. It raises a loss-of-signal level when the line has carried nothing but zeros (spaces) for a long unbroken stretch. It drops that level again only once the line shows enough ones (marks) inside a sliding window of the most recent bits.

Two different criteria are used. The declare side is a saturating zero-run counter that any mark restarts. The clear side keeps a shift history of the last window of bits with a running mark count. The current level is presented on `los_o` for status. A one-cycle pulse on `los_change_o` marks every transition in either direction and feeds a sticky interrupt flag elsewhere in the chip.

Top module: `los_detector`

## Requirements
- R1: After reset is released, `los_o` is 1, `los_change_o` is 0, the zero run is empty and the mark window holds no marks.
- R2: While `los_o` is 0, the valid bit that completes a run of 180 consecutive valid zeros sets `los_o` to 1 on the clock edge that samples it.
- R3: A valid one restarts the zero run, so 179 zeros, a one and 179 more zeros leave `los_o` at 0.
- R4: While `los_o` is 1, the valid bit that brings the number of ones among the most recent 180 valid bits to 60 clears `los_o` on the clock edge that samples it.
- R5: With 59 or fewer ones among the most recent 180 valid bits, `los_o` stays 1, including when older ones have slid out of the window.
- R6: `los_change_o` is 1 for exactly the one cycle after each edge where `los_o` changes, in both directions, and is 0 at all other times.
- R7: Cycles with `bit_valid_i` low have no effect: the level, the zero run and the window hold whatever `bit_i` carries.
- R8: The zero run saturates at 180, so further zeros while `los_o` is 1 produce no further change pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_valid_i | input | 1 | Qualifies `bit_i` for this cycle |
| bit_i | input | 1 | Recovered line bit, 1 = mark, 0 = space |
| los_o | output | 1 | Current loss-of-signal level |
| los_change_o | output | 1 | One-cycle pulse on every change of `los_o` |

## Verification
Both outputs are registered. A bit driven with its valid at a falling edge is sampled at the next rising edge, and the level and the pulse it causes are visible from that edge on. The bench drives on falling edges and samples both outputs at the following falling edge, one cycle after the stimulus. It checks that the pulse is gone one further cycle later. Every valid bit is also compared against an arithmetic model of the zero run and the 180-bit window held in the bench.

// File: rtl/los_pkg.sv
`timescale 1ns/1ps
package los_pkg;
  localparam int unsigned LOS_WIN_LEN_DEF    = 180;
  localparam int unsigned LOS_DECL_RUN_DEF   = 180;
  localparam int unsigned LOS_CLR_MARKS_DEF  = 60;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/los_zero_run.sv
`timescale 1ns/1ps
module los_zero_run #(
  parameter int unsigned DECL_RUN = los_pkg::LOS_DECL_RUN_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic bit_i,
  output logic at_limit_o
);
  localparam int unsigned RW = los_pkg::cnt_width(DECL_RUN);
  localparam logic [RW-1:0] LIMIT = RW'(DECL_RUN);

  logic [RW-1:0] run_q, run_d;

  always_comb begin
    if (bit_i)               run_d = '0;
    else if (run_q == LIMIT) run_d = run_q;
    else                     run_d = run_q + 1'b1;
  end

  // look-ahead: true when the bit being sampled completes the run
  assign at_limit_o = valid_i && (run_d == LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (valid_i) run_q <= run_d;
  end

  a_r8_run_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= LIMIT);
  a_r3_one_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && bit_i) |=> (run_q == '0));
  a_r7_run_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(run_q));
endmodule

// File: rtl/los_mark_window.sv
`timescale 1ns/1ps
module los_mark_window #(
  parameter int unsigned WIN_LEN = los_pkg::LOS_WIN_LEN_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic bit_i,
  output logic [los_pkg::cnt_width(WIN_LEN)-1:0] marks_d_o
);
  localparam int unsigned CW = los_pkg::cnt_width(WIN_LEN);

  logic [WIN_LEN-1:0] hist_q;
  logic [CW-1:0]      marks_q;
  logic               leave;

  assign leave     = hist_q[WIN_LEN-1];
  assign marks_d_o = marks_q + CW'(bit_i) - CW'(leave);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q  <= '0;
      marks_q <= '0;
    end else if (valid_i) begin
      hist_q  <= {hist_q[WIN_LEN-2:0], bit_i};
      marks_q <= marks_d_o;
    end
  end

  a_r4_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    marks_q <= CW'(WIN_LEN));
  a_r4_count_matches_hist: assert property (@(posedge clk_i) disable iff (!rst_ni)
    marks_q == CW'($countones(hist_q)));
  a_r7_window_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(marks_q) && $stable(hist_q)));
endmodule

// File: rtl/los_state.sv
`timescale 1ns/1ps
module los_state #(
  parameter int unsigned WIN_LEN   = los_pkg::LOS_WIN_LEN_DEF,
  parameter int unsigned CLR_MARKS = los_pkg::LOS_CLR_MARKS_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic run_limit_i,
  input  logic [los_pkg::cnt_width(WIN_LEN)-1:0] marks_d_i,
  output logic los_o,
  output logic change_o
);
  localparam int unsigned CW = los_pkg::cnt_width(WIN_LEN);
  localparam logic [CW-1:0] CLR_TH = CW'(CLR_MARKS);

  logic los_q, los_d, chg_q;

  always_comb begin
    los_d = los_q;
    if (valid_i) begin
      if (!los_q && run_limit_i)        los_d = 1'b1;
      else if (los_q && marks_d_i >= CLR_TH) los_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      los_q <= 1'b1;
      chg_q <= 1'b0;
    end else begin
      los_q <= los_d;
      chg_q <= los_d ^ los_q;
    end
  end

  assign los_o    = los_q;
  assign change_o = chg_q;

  a_r6_pulse_tracks_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (los_q != $past(los_q)) == chg_q);
  a_r6_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_q |=> !chg_q);
  a_r7_level_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(los_q));
  a_r2_rise_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!los_q && !run_limit_i) |=> !los_q);
  a_r4_fall_needs_marks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (los_q && valid_i && marks_d_i < CLR_TH) |=> los_q);
endmodule

// File: rtl/los_detector.sv
`timescale 1ns/1ps
module los_detector #(
  parameter int unsigned WIN_LEN   = los_pkg::LOS_WIN_LEN_DEF,
  parameter int unsigned DECL_RUN  = los_pkg::LOS_DECL_RUN_DEF,
  parameter int unsigned CLR_MARKS = los_pkg::LOS_CLR_MARKS_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_valid_i,
  input  logic bit_i,
  output logic los_o,
  output logic los_change_o
);
  localparam int unsigned CW = los_pkg::cnt_width(WIN_LEN);

  logic          run_limit;
  logic [CW-1:0] marks_d;

  los_zero_run #(.DECL_RUN(DECL_RUN)) i_zero_run (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (bit_valid_i),
    .bit_i      (bit_i),
    .at_limit_o (run_limit)
  );

  los_mark_window #(.WIN_LEN(WIN_LEN)) i_mark_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (bit_valid_i),
    .bit_i     (bit_i),
    .marks_d_o (marks_d)
  );

  los_state #(.WIN_LEN(WIN_LEN), .CLR_MARKS(CLR_MARKS)) i_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (bit_valid_i),
    .run_limit_i (run_limit),
    .marks_d_i   (marks_d),
    .los_o       (los_o),
    .change_o    (los_change_o)
  );
endmodule

// File: tb/test_los_detector.sv
`timescale 1ns/1ps
module test_los_detector;
  localparam int WIN = 180;
  localparam int RUN = 180;
  localparam int CLR = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic bit_in = 1'b0;
  logic los, chg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model
  bit m_hist [WIN];
  int m_head = 0;
  int m_ones = 0;
  int m_run  = 0;
  bit m_los  = 1'b1;
  bit m_chg  = 1'b0;

  always #2.5 clk = ~clk;

  los_detector i_los_detector (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bit_valid_i  (valid),
    .bit_i        (bit_in),
    .los_o        (los),
    .los_change_o (chg)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit b);
    bit prev;
    bit lv;
    lv = m_hist[m_head];
    m_hist[m_head] = b;
    m_head = (m_head + 1) % WIN;
    m_ones = m_ones + int'(b) - int'(lv);
    m_run = b ? 0 : ((m_run == RUN) ? RUN : m_run + 1);
    prev = m_los;
    if (!m_los && m_run == RUN)      m_los = 1'b1;
    else if (m_los && m_ones >= CLR) m_los = 1'b0;
    m_chg = (prev != m_los);
  endtask

  // called at a falling edge; returns at the next falling edge with outputs sampled
  task automatic send(input bit b);
    valid = 1'b1;
    bit_in = b;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    model_step(b);
    if (m_chg) begin
      chk(los == m_los, m_los ? "R2 declare edge" : "R4 clear edge", int'(los), int'(m_los));
      chk(chg == 1'b1, "R6 pulse on change", int'(chg), 1);
    end else begin
      chk(los == m_los, "R3/R5 level vs model", int'(los), int'(m_los));
      chk(chg == 1'b0, "R6 no pulse without change", int'(chg), 0);
    end
  endtask

  task automatic send_n(input bit b, input int n);
    for (int i = 0; i < n; i++) send(b);
  endtask

  task automatic idle(input bit b, input int n, input bit exp_los);
    for (int i = 0; i < n; i++) begin
      valid = 1'b0;
      bit_in = b;
      @(posedge clk);
      @(negedge clk);
      m_chg = 1'b0;
      chk(los == exp_los, "R7 level held while invalid", int'(los), int'(exp_los));
      chk(chg == 1'b0, "R7 no pulse while invalid", int'(chg), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(los == 1'b1, "R1 los in reset", int'(los), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(los == 1'b1, "R1 los after reset", int'(los), 1);
    chk(chg == 1'b0, "R1 no pulse after reset", int'(chg), 0);

    // R5: 59 marks, then spaces: still in LOS
    send_n(1'b1, 59);
    send_n(1'b0, 100);
    chk(los == 1'b1, "R5 59 marks do not clear", int'(los), 1);
    // R4: the 60th mark inside the window clears
    send(1'b1);
    chk(los == 1'b0, "R4 60th mark clears", int'(los), 0);
    chk(chg == 1'b1, "R6 pulse on clear", int'(chg), 1);
    idle(1'b1, 1, 1'b0);
    chk(chg == 1'b0, "R6 pulse lasts one cycle", int'(chg), 0);

    // R7: invalid cycles ignored, long enough to declare if counted
    idle(1'b0, 400, 1'b0);

    // R3: one mark restarts the run
    send_n(1'b0, 179);
    send(1'b1);
    send_n(1'b0, 179);
    chk(los == 1'b0, "R3 run restarted by mark", int'(los), 0);
    // R2: 180th consecutive space declares
    send(1'b0);
    chk(los == 1'b1, "R2 180th space declares", int'(los), 1);
    chk(chg == 1'b1, "R6 pulse on declare", int'(chg), 1);

    // R8: run saturates, no further pulses
    for (int i = 0; i < 400; i++) begin
      send(1'b0);
      chk(chg == 1'b0, "R8 no repeat pulse", int'(chg), 0);
    end
    chk(los == 1'b1, "R8 level held", int'(los), 1);

    // R5 sliding: old marks leave, count never reaches 60
    send_n(1'b1, 30);
    send_n(1'b0, 150);
    send_n(1'b1, 30);
    chk(los == 1'b1, "R5 sliding window below threshold", int'(los), 1);
    chk(m_ones == 30, "R5 model window count", m_ones, 30);
    idle(1'b1, 100, 1'b1);

    // mixed random stream against the model
    for (int blk = 0; blk < 120; blk++) begin
      int zl = $urandom_range(0, 260);
      int ml = $urandom_range(0, 200);
      send_n(1'b0, zl);
      for (int i = 0; i < ml; i++) send(($urandom_range(0, 2) == 0) ? 1'b1 : 1'b0);
      if ((blk % 10) == 0) idle(1'b1, 5, m_los);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule